// File: doc/BRIEF.md
# Delay-Slot Next-PC Unit

This block produces the fetch address for a five-stage pipeline whose branches and jumps are resolved in the decode stage. When a control-transfer instruction sits in decode, the instruction just after it (the delay slot) is already being fetched, so the redirect applies to the fetch that follows the slot. The slot is therefore never fetched twice. The unit owns the fetch address register. It evaluates the branch condition on two register operands and forms the target from one of three sources: a 16-bit word offset, a 26-bit word index inside the current 256 MB region, or a full address held in a register.

Link-type jumps ask for a write of the return address to register 31. That address is the word after the delay slot. A branch-likely form of the equality test cancels its delay slot when the test fails. The annul flag is registered so that it is high while the slot instruction sits in decode. A global advance input stalls the unit: with advance low, both the fetch address and the annul flag keep their values. The reset is asynchronous and active low, and its release passes through a two-stage synchronizer.

Top module: `nextpc_unit`

## Requirements
- R1: While reset is held, and until the first cycle with advance high after reset, fetch_pc equals RESET_PC (default 0x00000100) and annul is 0.
- R2: On a cycle with advance high and no taken transfer, fetch_pc becomes fetch_pc + 4 at the next edge.
- R3: A taken conditional branch sends fetch_pc at the next edge to (dec_pc + 4) + the sign-extended value of br_off shifted left by 2. Negative offsets go backward.
- R4: Operation codes 1 (equal) and 2 (not equal) compare opa with opb. Code 7 (equal-likely) takes the branch on the same condition as code 1.
- R5: Codes 3 (opa > 0), 4 (opa >= 0), 5 (opa <= 0) and 6 (opa < 0) test opa as a signed number.
- R6: Codes 8 (jump) and 9 (jump-and-link) are always taken. Their target is the upper 4 bits of dec_pc + 4 followed by jmp_idx and two zero bits.
- R7: Codes 10 (register jump) and 11 (register jump-and-link) are always taken, with jmp_reg as the target.
- R8: For codes 9 and 11, link_we is 1 and link_val is dec_pc + 8 in the same cycle. For every other code, link_we is 0.
- R9: After an advancing cycle with code 7 whose test fails, annul is 1. After any other advancing cycle, including code 7 taken, annul is 0.
- R10: With advance low, fetch_pc and annul keep their values.
- R11: With dec_valid low, the operation inputs are ignored: taken and link_we are 0 and fetch_pc steps by 4. Code 0 and codes 12 to 15 are never taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| advance | input | 1 | Pipeline advance enable |
| dec_valid | input | 1 | Decode stage holds a valid instruction |
| dec_op | input | 4 | Control-transfer operation code |
| opa | input | XLEN | First register operand |
| opb | input | XLEN | Second register operand |
| br_off | input | 16 | Conditional branch word offset |
| jmp_idx | input | 26 | Direct jump word index |
| jmp_reg | input | AW | Register jump target |
| dec_pc | input | AW | Address of the instruction in decode |
| fetch_pc | output | AW | Next fetch address |
| taken | output | 1 | Transfer in decode is taken |
| link_we | output | 1 | Write return address to register 31 |
| link_val | output | AW | Return address |
| annul | output | 1 | Squash the delay-slot instruction now in decode |

## Verification
The hardest case to reach is the interaction between a cancelled delay slot and a stall. The bench issues an equal-likely branch whose test fails and then holds advance low for a cycle, so the annul flag has to persist through the stall. Only the next advancing cycle may clear it. The bench also starts a direct jump from the last word of a 256 MB region, so that the delay-slot address, not the branch address, provides the region bits. It also uses negative offsets and operand values at the sign boundary for each zero-compare condition.

// File: rtl/nextpc_pkg.sv
package nextpc_pkg;
  typedef enum logic [3:0] {
    OP_NONE = 4'd0,
    OP_BEQ  = 4'd1,
    OP_BNE  = 4'd2,
    OP_BGTZ = 4'd3,
    OP_BGEZ = 4'd4,
    OP_BLEZ = 4'd5,
    OP_BLTZ = 4'd6,
    OP_BEQL = 4'd7,
    OP_J    = 4'd8,
    OP_JAL  = 4'd9,
    OP_JR   = 4'd10,
    OP_JALR = 4'd11
  } br_op_e;
endpackage

// File: rtl/branch_cond.sv
module branch_cond
  import nextpc_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  br_op_e            op,
  input  logic [XLEN-1:0]   a,
  input  logic [XLEN-1:0]   b,
  output logic              take
);
  logic a_neg, a_zero, a_eq_b;

  always_comb begin
    a_neg  = a[XLEN-1];
    a_zero = (a == '0);
    a_eq_b = (a == b);
    case (op)
      OP_BEQ, OP_BEQL:                 take = a_eq_b;
      OP_BNE:                          take = !a_eq_b;
      OP_BGTZ:                         take = !a_neg && !a_zero;
      OP_BGEZ:                         take = !a_neg;
      OP_BLEZ:                         take = a_neg || a_zero;
      OP_BLTZ:                         take = a_neg;
      OP_J, OP_JAL, OP_JR, OP_JALR:    take = 1'b1;
      default:                         take = 1'b0;
    endcase
  end
endmodule

// File: rtl/target_gen.sv
module target_gen
  import nextpc_pkg::*;
#(
  parameter int AW = 32
) (
  input  br_op_e          op,
  input  logic [AW-1:0]   pc,
  input  logic [15:0]     off,
  input  logic [25:0]     idx,
  input  logic [AW-1:0]   reg_tgt,
  output logic [AW-1:0]   tgt,
  output logic [AW-1:0]   ret_addr
);
  localparam int REGION = 28;
  localparam int EXT    = AW - 18;

  logic [AW-1:0] slot_pc, off_ext, br_tgt, j_tgt;

  always_comb begin
    slot_pc  = pc + AW'(4);
    ret_addr = pc + AW'(8);
    off_ext  = {{EXT{off[15]}}, off, 2'b00};
    br_tgt   = slot_pc + off_ext;
    j_tgt    = {slot_pc[AW-1:REGION], idx, 2'b00};
    case (op)
      OP_J, OP_JAL:   tgt = j_tgt;
      OP_JR, OP_JALR: tgt = reg_tgt;
      default:        tgt = br_tgt;
    endcase
  end
endmodule

// File: rtl/nextpc_unit.sv
module nextpc_unit
  import nextpc_pkg::*;
#(
  parameter int          XLEN     = 32,
  parameter int          AW       = 32,
  parameter int          SYNC     = 2,
  parameter logic [31:0] RESET_PC = 32'h0000_0100
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            advance,
  input  logic            dec_valid,
  input  logic [3:0]      dec_op,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  input  logic [15:0]     br_off,
  input  logic [25:0]     jmp_idx,
  input  logic [AW-1:0]   jmp_reg,
  input  logic [AW-1:0]   dec_pc,
  output logic [AW-1:0]   fetch_pc,
  output logic            taken,
  output logic            link_we,
  output logic [AW-1:0]   link_val,
  output logic            annul
);
  localparam logic [AW-1:0] PC_INIT = AW'(RESET_PC);

  logic [SYNC-1:0] rst_pipe;
  logic            rst_q_n;
  br_op_e          op;
  logic            cond_take;
  logic [AW-1:0]   tgt;
  logic [AW-1:0]   fpc_d;
  logic            annul_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[SYNC-2:0], 1'b1};
  end
  assign rst_q_n = rst_pipe[SYNC-1];

  assign op = br_op_e'(dec_op);

  branch_cond #(.XLEN(XLEN)) u_cond (
    .op   (op),
    .a    (opa),
    .b    (opb),
    .take (cond_take)
  );

  target_gen #(.AW(AW)) u_tgt (
    .op       (op),
    .pc       (dec_pc),
    .off      (br_off),
    .idx      (jmp_idx),
    .reg_tgt  (jmp_reg),
    .tgt      (tgt),
    .ret_addr (link_val)
  );

  always_comb begin
    taken   = dec_valid && cond_take;
    link_we = dec_valid && ((op == OP_JAL) || (op == OP_JALR));
    fpc_d   = taken ? tgt : (fetch_pc + AW'(4));
    annul_d = dec_valid && (op == OP_BEQL) && !cond_take;
  end

  always_ff @(posedge clk or negedge rst_q_n) begin
    if (!rst_q_n) begin
      fetch_pc <= PC_INIT;
      annul    <= 1'b0;
    end else if (advance) begin
      fetch_pc <= fpc_d;
      annul    <= annul_d;
    end
  end
endmodule

// File: rtl/nextpc_unit_chk.sv
module nextpc_unit_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_q_n,
  input logic          advance,
  input logic          dec_valid,
  input logic [3:0]    dec_op,
  input logic          taken,
  input logic          link_we,
  input logic [AW-1:0] fetch_pc,
  input logic          annul
);
  // R2
  fetch_step_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (advance && !taken) |=> (fetch_pc == $past(fetch_pc) + AW'(4)));

  // R10
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !advance |=> ($stable(fetch_pc) && $stable(annul)));

  // R9
  annul_src_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    $rose(annul) |-> $past(advance && dec_valid && (dec_op == 4'd7)));

  // R8
  link_taken_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    link_we |-> taken);

  // R11
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    !dec_valid |-> (!taken && !link_we));

  // R6
  jump_always_chk: assert property (@(posedge clk) disable iff (!rst_q_n)
    (dec_valid && (dec_op == 4'd8)) |-> taken);
endmodule

bind nextpc_unit nextpc_unit_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst_q_n   (rst_q_n),
  .advance   (advance),
  .dec_valid (dec_valid),
  .dec_op    (dec_op),
  .taken     (taken),
  .link_we   (link_we),
  .fetch_pc  (fetch_pc),
  .annul     (annul)
);

// File: tb/nextpc_unit_bench.sv
module nextpc_unit_bench;
  localparam int CLK_PERIOD = 10;
  localparam int XLEN = 32;
  localparam int AW   = 32;
  localparam logic [31:0] RST_PC = 32'h0000_0100;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            advance;
  logic            dec_valid;
  logic [3:0]      dec_op;
  logic [XLEN-1:0] opa, opb;
  logic [15:0]     br_off;
  logic [25:0]     jmp_idx;
  logic [AW-1:0]   jmp_reg, dec_pc;
  logic [AW-1:0]   fetch_pc, link_val;
  logic            taken, link_we, annul;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  typedef struct {
    string       tag;
    logic        e_taken;
    logic        e_link;
    logic [31:0] e_lval;
    logic [31:0] e_fpc;
    logic        e_annul;
  } item_t;

  item_t sb[$];
  logic [31:0] m_fpc;
  logic        m_annul;

  always #(CLK_PERIOD/2) clk = ~clk;

  nextpc_unit #(.XLEN(XLEN), .AW(AW), .RESET_PC(RST_PC)) u_nextpc_unit (
    .clk(clk), .rst_n(rst_n), .advance(advance), .dec_valid(dec_valid),
    .dec_op(dec_op), .opa(opa), .opb(opb), .br_off(br_off),
    .jmp_idx(jmp_idx), .jmp_reg(jmp_reg), .dec_pc(dec_pc),
    .fetch_pc(fetch_pc), .taken(taken), .link_we(link_we),
    .link_val(link_val), .annul(annul)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic cond_of(logic [3:0] op, logic [31:0] a, logic [31:0] b);
    case (op)
      4'd1, 4'd7: return a == b;
      4'd2:       return a != b;
      4'd3:       return $signed(a) > 0;
      4'd4:       return $signed(a) >= 0;
      4'd5:       return $signed(a) <= 0;
      4'd6:       return $signed(a) < 0;
      4'd8, 4'd9, 4'd10, 4'd11: return 1'b1;
      default:    return 1'b0;
    endcase
  endfunction

  task automatic drive(string tag, logic v, logic [3:0] op, logic [31:0] a,
                       logic [31:0] b, logic [15:0] off, logic [25:0] idx,
                       logic [31:0] rg, logic [31:0] pc, logic adv);
    item_t it;
    logic [31:0] slot, tgt;
    @(negedge clk);
    dec_valid = v; dec_op = op; opa = a; opb = b; br_off = off;
    jmp_idx = idx; jmp_reg = rg; dec_pc = pc; advance = adv;
    slot = pc + 32'd4;
    if (op == 4'd8 || op == 4'd9)       tgt = {slot[31:28], idx, 2'b00};
    else if (op == 4'd10 || op == 4'd11) tgt = rg;
    else tgt = slot + {{14{off[15]}}, off, 2'b00};
    it.tag     = tag;
    it.e_taken = v && cond_of(op, a, b);
    it.e_link  = v && (op == 4'd9 || op == 4'd11);
    it.e_lval  = pc + 32'd8;
    if (adv) begin
      m_fpc   = it.e_taken ? tgt : m_fpc + 32'd4;
      m_annul = v && (op == 4'd7) && (a != b);
    end
    it.e_fpc   = m_fpc;
    it.e_annul = m_annul;
    sb.push_back(it);
  endtask

  initial begin : monitor
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        it = sb.pop_front();
        check(it.tag, "taken", {31'd0, taken}, {31'd0, it.e_taken});
        check(it.tag, "link_we", {31'd0, link_we}, {31'd0, it.e_link});
        if (it.e_link) check(it.tag, "link_val", link_val, it.e_lval);
        check(it.tag, "fetch_pc", fetch_pc, it.e_fpc);
        check(it.tag, "annul", {31'd0, annul}, {31'd0, it.e_annul});
      end
    end
  end

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end

  initial begin : stim
    rst_n = 1'b0; advance = 1'b0; dec_valid = 1'b0; dec_op = 4'd0;
    opa = '0; opb = '0; br_off = '0; jmp_idx = '0; jmp_reg = '0; dec_pc = '0;
    repeat (3) @(negedge clk);
    check("R1", "fetch_pc in reset", fetch_pc, RST_PC);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check("R1", "fetch_pc after release", fetch_pc, RST_PC);
    check("R1", "annul after release", {31'd0, annul}, 32'd0);
    m_fpc = RST_PC; m_annul = 1'b0;

    drive("R2 sequential", 1, 4'd0, 0, 0, 0, 0, 0, 32'h100, 1);
    drive("R11 idle ignores jal", 0, 4'd9, 0, 0, 16'h0010, 26'h1, 0, 32'h104, 1);
    drive("R11 code 13", 1, 4'd13, 5, 5, 16'h0010, 0, 0, 32'h108, 1);
    drive("R4 R3 beq taken fwd", 1, 4'd1, 32'h55, 32'h55, 16'h0010, 0, 0, 32'h1000, 1);
    drive("R4 beq not taken", 1, 4'd1, 32'h55, 32'h56, 16'h0010, 0, 0, 32'h1000, 1);
    drive("R4 R3 bne taken back", 1, 4'd2, 32'h1, 32'h2, 16'hFFF0, 0, 0, 32'h2000, 1);
    drive("R4 bne not taken", 1, 4'd2, 32'h7, 32'h7, 16'hFFF0, 0, 0, 32'h2000, 1);
    drive("R5 bgtz pos", 1, 4'd3, 32'h1, 0, 16'h0004, 0, 0, 32'h3000, 1);
    drive("R5 bgtz zero", 1, 4'd3, 32'h0, 0, 16'h0004, 0, 0, 32'h3000, 1);
    drive("R5 bgtz neg", 1, 4'd3, 32'h8000_0000, 0, 16'h0004, 0, 0, 32'h3000, 1);
    drive("R5 bgez zero", 1, 4'd4, 32'h0, 0, 16'hFFFF, 0, 0, 32'h3100, 1);
    drive("R5 bgez neg", 1, 4'd4, 32'hFFFF_FFFF, 0, 16'hFFFF, 0, 0, 32'h3100, 1);
    drive("R5 blez zero", 1, 4'd5, 32'h0, 0, 16'h8000, 0, 0, 32'h0004_0000, 1);
    drive("R5 blez pos", 1, 4'd5, 32'h7FFF_FFFF, 0, 16'h8000, 0, 0, 32'h0004_0000, 1);
    drive("R5 bltz neg", 1, 4'd6, 32'h8000_0000, 0, 16'h7FFF, 0, 0, 32'h5000, 1);
    drive("R5 bltz zero", 1, 4'd6, 32'h0, 0, 16'h7FFF, 0, 0, 32'h5000, 1);
    drive("R9 beql taken", 1, 4'd7, 32'h9, 32'h9, 16'hFFFE, 0, 0, 32'h6000, 1);
    drive("R9 beql not taken", 1, 4'd7, 32'h9, 32'hA, 16'hFFFE, 0, 0, 32'h6000, 1);
    drive("R10 stall keeps annul", 1, 4'd1, 32'h3, 32'h3, 16'h0100, 0, 0, 32'h6004, 0);
    drive("R9 annul clears", 1, 4'd0, 0, 0, 0, 0, 0, 32'h6008, 1);
    drive("R9 other branch no annul", 1, 4'd2, 32'h3, 32'h3, 16'h0100, 0, 0, 32'h600C, 1);
    drive("R6 j region", 1, 4'd8, 0, 0, 0, 26'h2AB_CDEF, 0, 32'h3FFF_FFFC, 1);
    drive("R6 R8 jal", 1, 4'd9, 0, 0, 0, 26'h000_0040, 0, 32'h8000_1000, 1);
    drive("R7 jr", 1, 4'd10, 0, 0, 0, 0, 32'hDEAD_BEE0, 32'h9000, 1);
    drive("R7 R8 jalr", 1, 4'd11, 0, 0, 0, 0, 32'h0000_4400, 32'hFFFF_FFF8, 1);
    drive("R10 stall on taken", 1, 4'd10, 0, 0, 0, 0, 32'h1234_5678, 32'hA000, 0);
    drive("R8 no link on jr", 1, 4'd10, 0, 0, 0, 0, 32'h0000_0800, 32'hA000, 1);
    drive("R2 after jump", 0, 4'd0, 0, 0, 0, 0, 0, 0, 1);
    @(negedge clk); advance = 1'b0; dec_valid = 1'b0;
    repeat (3) @(negedge clk);
    done = 1'b1;
    finish_run();
  end
endmodule